// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output compare channel for a timer. Each clock it compares the timer's counter value, supplied from outside, against its active compare register. From that result, a three-bit mode setting and the counting direction it computes a reference waveform. The mode picks one of eight behaviours: hold, set on equality, clear on equality, toggle on equality, forced low, forced high, and two pulse-width-modulation senses.

The reference is then conditioned for the pin. A polarity input can invert it, and an enable input can park the pin at its idle level. The compare register has a shadow copy. When preload is on, writes land in the shadow and reach the active register only when the timer signals an update event, so a new duty cycle takes effect at a period boundary. When preload is off, writes go straight to the active register.

A sticky flag records every equality between counter and compare value until it is cleared. All outputs are registered and change one clock after the inputs that cause them.

Top module: `tmr_oc_channel`

## Requirements
- R1: While `rst` is high at a clock edge, `ref_o`, `pin_o` and `match_flag_o` go to 0 and both the active and the shadow compare registers go to 0.
- R2: With mode 3'b000 (hold), `ref_o` keeps its value whatever the counter does.
- R3: With mode 3'b001, `ref_o` becomes 1 after a clock where `cnt_i` equals the active compare value. With mode 3'b010 it becomes 0 in that case. In both modes it holds otherwise.
- R4: With mode 3'b011, `ref_o` inverts after each clock where `cnt_i` equals the active compare value, and holds otherwise.
- R5: Mode 3'b100 drives `ref_o` to 0 and mode 3'b101 drives it to 1, regardless of the comparison.
- R6: With mode 3'b110, when `dir_down_i` is 0, `ref_o` is 1 if `cnt_i` < compare and 0 otherwise. When `dir_down_i` is 1, `ref_o` is 0 if `cnt_i` > compare and 1 otherwise.
- R7: Mode 3'b111 gives the inverse of the mode 3'b110 result for the same counter, compare value and direction.
- R8: When `chan_en_i` is 1, `pin_o` equals the new `ref_o` XOR `pol_inv_i`, where `pol_inv_i` = 1 means the pin is active low.
- R9: When `chan_en_i` is 0, `pin_o` goes to the idle level, which equals `pol_inv_i`, and `ref_o` keeps following its mode.
- R10: When `preload_en_i` is 0, `cmp_wr_i` loads `cmp_wdata_i` into the active compare register. When it is 1, the write goes to the shadow only, and `update_i` copies the shadow as it was before that clock into the active register. A write and an update in the same clock therefore move the old shadow to active and store the new data in the shadow.
- R11: `match_flag_o` becomes 1 after any clock where `cnt_i` equals the active compare value. It stays 1 until a clock with `match_clr_i` high and no equality. If equality and clear occur in the same clock, the flag is set.
- R12: `ref_o`, `pin_o` and `match_flag_o` are registered. They change on the clock edge that samples the causing inputs, and never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Timer counter value |
| dir_down_i | input | 1 | Counting direction, 1 = down |
| update_i | input | 1 | Timer update event pulse |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value to write |
| preload_en_i | input | 1 | 1 = writes go through the shadow register |
| mode_i | input | 3 | Compare behaviour select |
| pol_inv_i | input | 1 | 1 = active-low pin |
| chan_en_i | input | 1 | Channel output enable |
| match_clr_i | input | 1 | Clears the match flag |
| pin_o | output | 1 | Channel pin level |
| ref_o | output | 1 | Reference waveform |
| match_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The hardest condition to reach from the ports is the one where the active and shadow compare values differ while the counter sweeps. Only that shows whether preload really defers a write. The hardest case within it is a write and an update event landing in the same clock. The stimulus writes a value with preload on and sweeps the counter in the pulse-width mode. The reference then still follows the old compare value. The bench then raises the update event, both alone and together with a further write, and sweeps again so that the active value shows in the duty cycle. Apart from this, every mode is swept over all compare values, all counter values, both directions and all polarity and enable combinations.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;

  typedef enum logic [2:0] {
    OC_HOLD     = 3'd0,
    OC_SET_EQ   = 3'd1,
    OC_CLR_EQ   = 3'd2,
    OC_TOGGLE   = 3'd3,
    OC_FORCE_LO = 3'd4,
    OC_FORCE_HI = 3'd5,
    OC_PWM_A    = 3'd6,
    OC_PWM_B    = 3'd7
  } oc_mode_e;

  localparam int OC_MODE_W = 3;

endpackage

// File: rtl/tmr_oc_cmpreg.sv
module tmr_oc_cmpreg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             preload,
  input  logic             update,
  output logic [CNT_W-1:0] cmp_act
);

  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] shd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      shd_q <= '0;
    end else begin
      if (wr) begin
        shd_q <= wdata;
      end
      if (wr && !preload) begin
        act_q <= wdata;
      end else if (update && preload) begin
        act_q <= shd_q;
      end
    end
  end

  assign cmp_act = act_q;

endmodule

// File: rtl/tmr_oc_refgen.sv
module tmr_oc_refgen
  import tmr_oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             dir_down,
  input  oc_mode_e         mode,
  output logic             eq,
  output logic             ref_d,
  output logic             ref_q
);

  logic below;
  logic above;
  logic pwm_lvl;

  assign eq    = (cnt == cmp);
  assign below = (cnt < cmp);
  assign above = (cnt > cmp);

  // Upcount: active while below. Downcount: inactive while above.
  assign pwm_lvl = dir_down ? !above : below;

  always_comb begin
    ref_d = ref_q;
    unique case (mode)
      OC_HOLD:     ref_d = ref_q;
      OC_SET_EQ:   ref_d = eq ? 1'b1 : ref_q;
      OC_CLR_EQ:   ref_d = eq ? 1'b0 : ref_q;
      OC_TOGGLE:   ref_d = eq ? !ref_q : ref_q;
      OC_FORCE_LO: ref_d = 1'b0;
      OC_FORCE_HI: ref_d = 1'b1;
      OC_PWM_A:    ref_d = pwm_lvl;
      OC_PWM_B:    ref_d = !pwm_lvl;
      default:     ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
    end
  end

endmodule

// File: rtl/tmr_oc_outstage.sv
module tmr_oc_outstage (
  input  logic clk,
  input  logic rst,
  input  logic ref_d,
  input  logic pol_inv,
  input  logic chan_en,
  input  logic eq,
  input  logic clr,
  output logic pin_q,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pin_q <= chan_en ? (ref_d ^ pol_inv) : pol_inv;
      if (eq) begin
        flag_q <= 1'b1;
      end else if (clr) begin
        flag_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tmr_oc_channel.sv
module tmr_oc_channel
  import tmr_oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 dir_down_i,
  input  logic                 update_i,
  input  logic                 cmp_wr_i,
  input  logic [CNT_W-1:0]     cmp_wdata_i,
  input  logic                 preload_en_i,
  input  logic [OC_MODE_W-1:0] mode_i,
  input  logic                 pol_inv_i,
  input  logic                 chan_en_i,
  input  logic                 match_clr_i,
  output logic                 pin_o,
  output logic                 ref_o,
  output logic                 match_flag_o
);

  logic [CNT_W-1:0] cmp_act;
  logic             eq;
  logic             ref_d;
  oc_mode_e         mode;

  assign mode = oc_mode_e'(mode_i);

  tmr_oc_cmpreg #(.CNT_W(CNT_W)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .wr      (cmp_wr_i),
    .wdata   (cmp_wdata_i),
    .preload (preload_en_i),
    .update  (update_i),
    .cmp_act (cmp_act)
  );

  tmr_oc_refgen #(.CNT_W(CNT_W)) u_ref (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_i),
    .cmp      (cmp_act),
    .dir_down (dir_down_i),
    .mode     (mode),
    .eq       (eq),
    .ref_d    (ref_d),
    .ref_q    (ref_o)
  );

  tmr_oc_outstage u_out (
    .clk     (clk),
    .rst     (rst),
    .ref_d   (ref_d),
    .pol_inv (pol_inv_i),
    .chan_en (chan_en_i),
    .eq      (eq),
    .clr     (match_clr_i),
    .pin_q   (pin_o),
    .flag_q  (match_flag_o)
  );

endmodule

// File: rtl/tmr_oc_channel_chk.sv
module tmr_oc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_act,
  input logic             update_i,
  input logic             preload_en_i,
  input logic [2:0]       mode_i,
  input logic             pol_inv_i,
  input logic             chan_en_i,
  input logic             match_clr_i,
  input logic             pin_o,
  input logic             ref_o,
  input logic             match_flag_o
);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd0) |=> (ref_o == $past(ref_o)));

  a_r3_set_on_eq: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd1 && cnt_i == cmp_act) |=> ref_o);

  a_r3_clr_on_eq: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd2 && cnt_i == cmp_act) |=> !ref_o);

  a_r4_toggle: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd3 && cnt_i == cmp_act) |=> (ref_o != $past(ref_o)));

  a_r5_force_low: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd4) |=> !ref_o);

  a_r5_force_high: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd5) |=> ref_o);

  a_r8_polarity: assert property (@(posedge clk) disable iff (rst)
    chan_en_i |=> (pin_o == (ref_o ^ $past(pol_inv_i))));

  a_r9_idle_level: assert property (@(posedge clk) disable iff (rst)
    !chan_en_i |=> (pin_o == $past(pol_inv_i)));

  a_r10_preload_hold: assert property (@(posedge clk) disable iff (rst)
    (preload_en_i && !update_i) |=> $stable(cmp_act));

  a_r11_flag_set: assert property (@(posedge clk) disable iff (rst)
    (cnt_i == cmp_act) |=> match_flag_o);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (match_flag_o && !match_clr_i) |=> match_flag_o);

endmodule

bind tmr_oc_channel tmr_oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cnt_i        (cnt_i),
  .cmp_act      (cmp_act),
  .update_i     (update_i),
  .preload_en_i (preload_en_i),
  .mode_i       (mode_i),
  .pol_inv_i    (pol_inv_i),
  .chan_en_i    (chan_en_i),
  .match_clr_i  (match_clr_i),
  .pin_o        (pin_o),
  .ref_o        (ref_o),
  .match_flag_o (match_flag_o)
);

// File: tb/tmr_oc_channel_tb.sv
module tmr_oc_channel_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int NV = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] cnt_i = '0;
  logic         dir_down_i = 1'b0;
  logic         update_i = 1'b0;
  logic         cmp_wr_i = 1'b0;
  logic [W-1:0] cmp_wdata_i = '0;
  logic         preload_en_i = 1'b0;
  logic [2:0]   mode_i = 3'd0;
  logic         pol_inv_i = 1'b0;
  logic         chan_en_i = 1'b0;
  logic         match_clr_i = 1'b0;
  logic         pin_o, ref_o, match_flag_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [W-1:0] m_act = '0;
  logic [W-1:0] m_shd = '0;
  logic         m_ref = 1'b0;
  logic         m_pin = 1'b0;
  logic         m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_oc_channel #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .dir_down_i(dir_down_i),
    .update_i(update_i), .cmp_wr_i(cmp_wr_i), .cmp_wdata_i(cmp_wdata_i),
    .preload_en_i(preload_en_i), .mode_i(mode_i), .pol_inv_i(pol_inv_i),
    .chan_en_i(chan_en_i), .match_clr_i(match_clr_i),
    .pin_o(pin_o), .ref_o(ref_o), .match_flag_o(match_flag_o)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b (mode %0d cnt %0d cmp %0d dir %0b)",
               tag, what, act, exp, mode_i, cnt_i, m_act, dir_down_i);
    end
  endtask

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Expected values derive from the requirement text; inputs are held across the edge.
  task automatic step(input string ptag);
    logic eq, lvl, nref, npin, nflag;
    logic [W-1:0] nact, nshd;
    eq = (cnt_i == m_act);
    lvl = dir_down_i ? (cnt_i <= m_act) : (cnt_i < m_act);
    case (mode_i)
      3'd0: nref = m_ref;
      3'd1: nref = eq ? 1'b1 : m_ref;
      3'd2: nref = eq ? 1'b0 : m_ref;
      3'd3: nref = eq ? ~m_ref : m_ref;
      3'd4: nref = 1'b0;
      3'd5: nref = 1'b1;
      3'd6: nref = lvl;
      default: nref = ~lvl;
    endcase
    npin = chan_en_i ? (nref ^ pol_inv_i) : pol_inv_i;
    nflag = eq ? 1'b1 : (match_clr_i ? 1'b0 : m_flag);
    nact = m_act;
    nshd = m_shd;
    if (cmp_wr_i) nshd = cmp_wdata_i;
    if (cmp_wr_i && !preload_en_i) nact = cmp_wdata_i;
    else if (update_i && preload_en_i) nact = m_shd;
    @(posedge clk);
    #1;
    m_ref = nref; m_pin = npin; m_flag = nflag; m_act = nact; m_shd = nshd;
    chk((ptag == "") ? mode_tag(mode_i) : ptag, "ref_o", ref_o, m_ref);
    chk(chan_en_i ? "R8" : "R9", "pin_o", pin_o, m_pin);
    chk("R11", "match_flag_o", match_flag_o, m_flag);
  endtask

  task automatic sweep_pwm(input string tag);
    for (int k = 0; k < NV; k++) begin
      cnt_i = W'(k);
      step(tag);
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    mode_i = 3'd5; chan_en_i = 1'b1; cnt_i = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "ref_o", ref_o, 1'b0);
    chk("R1", "pin_o", pin_o, 1'b0);
    chk("R1", "match_flag_o", match_flag_o, 1'b0);
    mode_i = 3'd0; chan_en_i = 1'b0;
    rst = 1'b0;
    // R1: compare reset to 0 -> counter 0 matches and sets the flag
    step("R1");

    // exhaustive sweep: enable/polarity x mode x compare x direction x counter
    for (int pe = 0; pe < 4; pe++) begin
      pol_inv_i = pe[0];
      chan_en_i = pe[1];
      for (int m = 0; m < 8; m++) begin
        mode_i = 3'(m);
        for (int c = 0; c < NV; c++) begin
          cmp_wr_i = 1'b1; cmp_wdata_i = W'(c); preload_en_i = 1'b0;
          cnt_i = W'(NV - 1 - c);
          step("R10");
          cmp_wr_i = 1'b0;
          for (int d = 0; d < 2; d++) begin
            dir_down_i = d[0];
            for (int k = 0; k < NV; k++) begin
              cnt_i = d[0] ? W'(NV - 1 - k) : W'(k);
              match_clr_i = (k == 5) || (k == c);
              step("");
            end
          end
          match_clr_i = 1'b0;
        end
      end
    end

    // R12: output does not move before the sampling edge
    chan_en_i = 1'b1; pol_inv_i = 1'b0; mode_i = 3'd4;
    step("R5");
    mode_i = 3'd5;
    #1;
    chk("R12", "ref_o before edge", ref_o, 1'b0);
    chk("R12", "pin_o before edge", pin_o, 1'b0);
    step("R12");
    chk("R12", "ref_o after edge", ref_o, 1'b1);

    // R10: preload defers the write until the update event
    mode_i = 3'd6; dir_down_i = 1'b0; preload_en_i = 1'b0;
    cmp_wr_i = 1'b1; cmp_wdata_i = W'(3);
    step("R10");
    preload_en_i = 1'b1; cmp_wdata_i = W'(11);
    step("R10");
    cmp_wr_i = 1'b0;
    sweep_pwm("R10");
    update_i = 1'b1;
    step("R10");
    update_i = 1'b0;
    sweep_pwm("R10");
    // write and update in the same clock
    cmp_wr_i = 1'b1; cmp_wdata_i = W'(6);
    step("R10");
    cmp_wdata_i = W'(9); update_i = 1'b1;
    step("R10");
    cmp_wr_i = 1'b0; update_i = 1'b0;
    sweep_pwm("R10");
    update_i = 1'b1;
    step("R10");
    update_i = 1'b0;
    sweep_pwm("R10");

    // R11: clear alone clears, clear with equality keeps the flag
    mode_i = 3'd0; preload_en_i = 1'b0;
    cnt_i = W'(0); match_clr_i = 1'b1;
    step("R11");
    chk("R11", "flag cleared", match_flag_o, 1'b0);
    cnt_i = W'(9);
    step("R11");
    chk("R11", "set wins over clear", match_flag_o, 1'b1);
    match_clr_i = 1'b0; cnt_i = W'(2);
    step("R11");

    done = 1'b1;
    finish_run();
  end

endmodule